// File: doc/BRIEF.md
# Processor Condition Code Register Unit

This unit keeps the status flags of a small 8-bit processor core: carry, overflow, zero, negative, half carry, the maskable interrupt mask and the non-maskable interrupt mask. Each cycle the ALU may present an operation class together with its result, its carry or borrow out, the carry out of bit 3 and the sign bits of both operands. The unit decides which flags that class is allowed to write and computes their new values.

Around the arithmetic flags sits the mask sequencing. A reset forces both masks to 1. An interrupt-entry strobe from the stacking sequencer sets the masks at the point where the vector fetch begins. A return-from-interrupt strobe reloads every flag from a restore bus in one cycle. Software set and clear commands act on the masks. The unit decodes two permission outputs from the masks, which the interrupt logic uses to decide whether a request may be taken.

Flag vector layout, used by both `flags` and `restore_bus`: bit 0 carry, bit 1 overflow, bit 2 zero, bit 3 negative, bit 4 half carry, bit 5 interrupt mask, bit 6 non-maskable mask.

Top module: `ccr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit loads flags 7'b1100000: both masks at 1 and all arithmetic flags at 0.
- R2: An update (`op_valid` high) of class 1 to 7 sets zero when the result is all zeros and copies the result MSB into negative. Class 0 and the codes 9 to 15 change no flag.
- R3: For the add classes (1 add, 2 add accumulators, 3 add with carry), overflow is set when both operand MSBs are equal and the result MSB differs from them. For subtract (4) and compare (5), overflow is set when the operand MSBs differ and the result MSB differs from the first operand's MSB.
- R4: Classes 1 to 5 and 7 load carry from `alu_carry`.
- R5: Half carry is written from `half_carry` only by classes 1, 2 and 3. Every other class leaves it unchanged.
- R6: Compare (class 5) writes the same flags, with the same values, as subtract (class 4).
- R7: Index step (class 8) writes zero from the result. All other flags hold.
- R8: Logic and data move (class 6) clears overflow and holds carry and half carry.
- R9: Shift and rotate (class 7) loads carry from `alu_carry` and sets overflow to negative XOR carry, both taken after the shift.
- R10: `int_enter` sets the interrupt mask. With `int_nmi` also high it sets the non-maskable mask as well. The arithmetic flags are not changed.
- R11: `restore` loads bits 0 to 5 from `restore_bus`. The non-maskable mask becomes its old value AND bit 6, so it can fall but never rise through a restore.
- R12: `sw_clr_imask` clears and `sw_set_imask` sets the interrupt mask (set wins if both are high). `sw_clr_xmask` clears the non-maskable mask. No command sets it. These commands take effect in the same cycle as an ALU update.
- R13: `irq_ok` is high exactly when the interrupt mask is 0, and `nmi_ok` is high exactly when the non-maskable mask is 0.
- R14: Priority within a cycle is reset first, then interrupt entry, then restore, then ALU update and software commands. A lower level is ignored when a higher one is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | ALU update request this cycle |
| op_class | input | 4 | Operation class code |
| result | input | DATA_W | ALU result |
| alu_carry | input | 1 | Carry or borrow out, or the bit shifted out |
| half_carry | input | 1 | Carry from bit 3 into bit 4 |
| opa_msb | input | 1 | Sign bit of the first operand |
| opb_msb | input | 1 | Sign bit of the second operand |
| int_enter | input | 1 | Interrupt entry point reached (stacking done) |
| int_nmi | input | 1 | The interrupt being entered is non-maskable |
| restore | input | 1 | Return-from-interrupt reload strobe |
| restore_bus | input | 7 | Flag values to reload |
| sw_set_imask | input | 1 | Software set of the interrupt mask |
| sw_clr_imask | input | 1 | Software clear of the interrupt mask |
| sw_clr_xmask | input | 1 | Software clear of the non-maskable mask |
| flags | output | 7 | Current flag register |
| irq_ok | output | 1 | Maskable interrupts may be taken |
| nmi_ok | output | 1 | Non-maskable interrupts may be taken |

## Verification
The assertions take the strobes as single-cycle pulses sampled at the clock edge and the ALU inputs as settled whenever `op_valid` is high. Several mask properties attribute each rise or fall of a mask to an input seen on the previous edge, so they assume no other path writes the masks. The stimulus changes inputs only on the falling edge and returns every strobe to 0 after one cycle. It puts strobes together in the same cycle only in the priority cases, where the intent is to have them collide.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_ADD    = 4'd1,
        OP_ADDACC = 4'd2,
        OP_ADC    = 4'd3,
        OP_SUB    = 4'd4,
        OP_CMP    = 4'd5,
        OP_LOGIC  = 4'd6,
        OP_SHIFT  = 4'd7,
        OP_IDX    = 4'd8
    } op_class_e;

    typedef struct packed {
        logic half;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } arith_flags_t;

    typedef struct packed {
        logic         xmask;
        logic         imask;
        arith_flags_t ar;
    } ccr_t;

    localparam int CCR_W   = $bits(ccr_t);
    localparam int ARITH_W = $bits(arith_flags_t);

    function automatic logic add_overflow(input logic a, input logic b, input logic r);
        return (a == b) && (r != a);
    endfunction

    function automatic logic sub_overflow(input logic a, input logic b, input logic r);
        return (a != b) && (r != a);
    endfunction

    function automatic logic is_add_class(input logic [3:0] c);
        return (c == OP_ADD) || (c == OP_ADDACC) || (c == OP_ADC);
    endfunction

endpackage

// File: rtl/ccr_flag_eval.sv
module ccr_flag_eval
    import ccr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              op_valid,
    input  logic [3:0]        op_class,
    input  logic [DATA_W-1:0] result,
    input  logic              alu_carry,
    input  logic              half_carry,
    input  logic              opa_msb,
    input  logic              opb_msb,
    input  arith_flags_t      cur,
    output arith_flags_t      nxt,
    output logic              upd
);
    localparam int MSB = DATA_W - 1;

    logic res_zero;
    logic res_neg;

    assign res_zero = ~|result;
    assign res_neg  = result[MSB];

    always_comb begin
        nxt = cur;
        upd = 1'b0;
        if (op_valid) begin
            unique case (op_class_e'(op_class))
                OP_ADD, OP_ADDACC, OP_ADC: begin
                    upd       = 1'b1;
                    nxt.zero  = res_zero;
                    nxt.neg   = res_neg;
                    nxt.carry = alu_carry;
                    nxt.half  = half_carry;
                    nxt.ovf   = add_overflow(opa_msb, opb_msb, res_neg);
                end
                OP_SUB, OP_CMP: begin
                    upd       = 1'b1;
                    nxt.zero  = res_zero;
                    nxt.neg   = res_neg;
                    nxt.carry = alu_carry;
                    nxt.ovf   = sub_overflow(opa_msb, opb_msb, res_neg);
                end
                OP_LOGIC: begin
                    upd       = 1'b1;
                    nxt.zero  = res_zero;
                    nxt.neg   = res_neg;
                    nxt.ovf   = 1'b0;
                end
                OP_SHIFT: begin
                    upd       = 1'b1;
                    nxt.zero  = res_zero;
                    nxt.neg   = res_neg;
                    nxt.carry = alu_carry;
                    nxt.ovf   = res_neg ^ alu_carry;
                end
                OP_IDX: begin
                    upd       = 1'b1;
                    nxt.zero  = res_zero;
                end
                default: begin
                    upd = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ccr_mask_ctrl.sv
module ccr_mask_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic int_enter,
    input  logic int_nmi,
    input  logic restore,
    input  logic restore_imask,
    input  logic restore_xmask,
    input  logic sw_set_imask,
    input  logic sw_clr_imask,
    input  logic sw_clr_xmask,
    output logic imask_q,
    output logic xmask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            imask_q <= 1'b1;
            xmask_q <= 1'b1;
        end else if (int_enter) begin
            imask_q <= 1'b1;
            if (int_nmi) begin
                xmask_q <= 1'b1;
            end
        end else if (restore) begin
            imask_q <= restore_imask;
            xmask_q <= xmask_q & restore_xmask;
        end else begin
            if (sw_set_imask) begin
                imask_q <= 1'b1;
            end else if (sw_clr_imask) begin
                imask_q <= 1'b0;
            end
            if (sw_clr_xmask) begin
                xmask_q <= 1'b0;
            end
        end
    end

    // R1: reset leaves both masks set
    p_reset_masks_r1: assert property (@(posedge clk)
        rst |=> (imask_q && xmask_q));

    // R11: the non-maskable mask rises only by reset or non-maskable entry
    p_xmask_rise_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(xmask_q) |-> $past(rst || (int_enter && int_nmi)));

    // R12: the interrupt mask falls only through restore or a software clear
    p_imask_fall_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(imask_q) |-> $past(restore || sw_clr_imask));

    // R10: interrupt entry always leaves the interrupt mask set
    p_entry_sets_imask_r10: assert property (@(posedge clk) disable iff (rst)
        int_enter |=> imask_q);

endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_class,
    input  logic [DATA_W-1:0] result,
    input  logic              alu_carry,
    input  logic              half_carry,
    input  logic              opa_msb,
    input  logic              opb_msb,
    input  logic              int_enter,
    input  logic              int_nmi,
    input  logic              restore,
    input  logic [CCR_W-1:0]  restore_bus,
    input  logic              sw_set_imask,
    input  logic              sw_clr_imask,
    input  logic              sw_clr_xmask,
    output logic [CCR_W-1:0]  flags,
    output logic              irq_ok,
    output logic              nmi_ok
);

    arith_flags_t ar_q;
    arith_flags_t ar_nxt;
    ccr_t         rbus;
    logic         alu_upd;
    logic         imask_q;
    logic         xmask_q;
    ccr_t         cur;

    assign rbus = ccr_t'(restore_bus);

    ccr_flag_eval #(.DATA_W(DATA_W)) u_eval (
        .op_valid   (op_valid),
        .op_class   (op_class),
        .result     (result),
        .alu_carry  (alu_carry),
        .half_carry (half_carry),
        .opa_msb    (opa_msb),
        .opb_msb    (opb_msb),
        .cur        (ar_q),
        .nxt        (ar_nxt),
        .upd        (alu_upd)
    );

    ccr_mask_ctrl u_mask (
        .clk           (clk),
        .rst           (rst),
        .int_enter     (int_enter),
        .int_nmi       (int_nmi),
        .restore       (restore),
        .restore_imask (rbus.imask),
        .restore_xmask (rbus.xmask),
        .sw_set_imask  (sw_set_imask),
        .sw_clr_imask  (sw_clr_imask),
        .sw_clr_xmask  (sw_clr_xmask),
        .imask_q       (imask_q),
        .xmask_q       (xmask_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q <= '0;
        end else if (int_enter) begin
            ar_q <= ar_q;
        end else if (restore) begin
            ar_q <= rbus.ar;
        end else if (alu_upd) begin
            ar_q <= ar_nxt;
        end
    end

    always_comb begin
        cur.xmask = xmask_q;
        cur.imask = imask_q;
        cur.ar    = ar_q;
    end

    assign flags  = cur;
    assign irq_ok = ~imask_q;
    assign nmi_ok = ~xmask_q;

    // R7: an index step leaves every flag but zero untouched
    p_idx_zero_only_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class == 4'd8 && !int_enter && !restore) |=>
        ($stable(flags[1:0]) && $stable(flags[4:3])));

    // R8: logic clears overflow and keeps carry and half carry
    p_logic_ovf_r8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class == 4'd6 && !int_enter && !restore) |=>
        (!flags[1] && $stable(flags[0]) && $stable(flags[4])));

    // R5: half carry is held by every ALU class outside the add group
    p_half_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!is_add_class(op_class) && !int_enter && !restore) |=> $stable(flags[4]));

    // R10: interrupt entry never alters the arithmetic flags
    p_entry_keeps_arith_r10: assert property (@(posedge clk) disable iff (rst)
        int_enter |=> $stable(flags[4:0]));

    // R9: after a shift, overflow equals negative XOR carry
    p_shift_ovf_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_class == 4'd7 && !int_enter && !restore) |=>
        (flags[1] == (flags[3] ^ flags[0])));

endmodule

// File: tb/tb_ccr_unit.sv
`timescale 1ns/1ps
module tb_ccr_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_class = 4'd0;
    logic [7:0] result = 8'h00;
    logic       alu_carry = 1'b0;
    logic       half_carry = 1'b0;
    logic       opa_msb = 1'b0;
    logic       opb_msb = 1'b0;
    logic       int_enter = 1'b0;
    logic       int_nmi = 1'b0;
    logic       restore = 1'b0;
    logic [6:0] restore_bus = 7'd0;
    logic       sw_set_imask = 1'b0;
    logic       sw_clr_imask = 1'b0;
    logic       sw_clr_xmask = 1'b0;
    logic [6:0] flags;
    logic       irq_ok;
    logic       nmi_ok;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    ccr_unit #(.DATA_W(8)) dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
        .result(result), .alu_carry(alu_carry), .half_carry(half_carry),
        .opa_msb(opa_msb), .opb_msb(opb_msb), .int_enter(int_enter),
        .int_nmi(int_nmi), .restore(restore), .restore_bus(restore_bus),
        .sw_set_imask(sw_set_imask), .sw_clr_imask(sw_clr_imask),
        .sw_clr_xmask(sw_clr_xmask), .flags(flags), .irq_ok(irq_ok),
        .nmi_ok(nmi_ok)
    );

    // {preset HNZVC, class, result, carry, half, a msb, b msb, expected HNZVC}
    localparam int NV = 15;
    localparam logic [25:0] VEC [NV] = '{
        {5'b00000, 4'd1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 5'b10111},
        {5'b00000, 4'd2, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 5'b01010},
        {5'b11111, 4'd3, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1, 5'b10000},
        {5'b10000, 4'd4, 8'h7F, 1'b0, 1'b0, 1'b1, 1'b0, 5'b10010},
        {5'b00000, 4'd5, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00101},
        {5'b00001, 4'd5, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 5'b01010},
        {5'b10011, 4'd6, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 5'b10101},
        {5'b00100, 4'd6, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b01000},
        {5'b00000, 4'd7, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 5'b01010},
        {5'b00000, 4'd7, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00111},
        {5'b10000, 4'd7, 8'hC0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b11001},
        {5'b11011, 4'd8, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 5'b11111},
        {5'b00100, 4'd8, 8'h05, 1'b1, 1'b1, 1'b1, 1'b1, 5'b00000},
        {5'b01101, 4'd0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 5'b01101},
        {5'b00000, 4'd4, 8'h12, 1'b1, 1'b1, 1'b0, 1'b0, 5'b00001}
    };
    localparam string VTAG [NV] = '{
        "R5", "R3", "R5", "R3", "R6", "R6", "R8", "R8",
        "R9", "R9", "R9", "R7", "R7", "R2", "R4"
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_valid = 1'b0; op_class = 4'd0; result = 8'h00; alu_carry = 1'b0;
        half_carry = 1'b0; opa_msb = 1'b0; opb_msb = 1'b0; int_enter = 1'b0;
        int_nmi = 1'b0; restore = 1'b0; restore_bus = 7'd0; sw_set_imask = 1'b0;
        sw_clr_imask = 1'b0; sw_clr_xmask = 1'b0; rst = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        idle();
        // R1, R13: reset state
        check("R1", {25'd0, flags}, {25'd0, 7'b1100000});
        check("R13", {30'd0, irq_ok, nmi_ok}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            restore = 1'b1; restore_bus = {2'b11, VEC[i][25:21]};
            settle();
            op_valid = 1'b1; op_class = VEC[i][20:17]; result = VEC[i][16:9];
            alu_carry = VEC[i][8]; half_carry = VEC[i][7];
            opa_msb = VEC[i][6]; opb_msb = VEC[i][5];
            settle();
            check(VTAG[i], {25'd0, flags}, {25'd0, 2'b11, VEC[i][4:0]});
        end

        // R12, R13: software clear of the interrupt mask
        sw_clr_imask = 1'b1;
        settle();
        check("R12", {25'd0, flags}, {25'd0, 7'b1000001});
        check("R13", {31'd0, irq_ok}, 32'd1);

        // R12, R13: software clear of the non-maskable mask
        sw_clr_xmask = 1'b1;
        settle();
        check("R12", {25'd0, flags}, {25'd0, 7'b0000001});
        check("R13", {31'd0, nmi_ok}, 32'd1);

        // R10, R14: maskable entry beats a same-cycle ALU update
        int_enter = 1'b1; op_valid = 1'b1; op_class = 4'd1; result = 8'h00; alu_carry = 1'b0;
        settle();
        check("R10", {25'd0, flags}, {25'd0, 7'b0100001});

        // R10: non-maskable entry sets both masks
        sw_clr_imask = 1'b1;
        settle();
        int_enter = 1'b1; int_nmi = 1'b1;
        settle();
        check("R10", {25'd0, flags}, {25'd0, 7'b1100001});

        // R11: restore may clear the non-maskable mask
        restore = 1'b1; restore_bus = 7'b0011111;
        settle();
        check("R11", {25'd0, flags}, {25'd0, 7'b0011111});

        // R11: restore cannot raise the non-maskable mask
        restore = 1'b1; restore_bus = 7'b1100000;
        settle();
        check("R11", {25'd0, flags}, {25'd0, 7'b0100000});

        // R12: set wins over clear, then clear, then set
        sw_clr_imask = 1'b1; sw_set_imask = 1'b1;
        settle();
        check("R12", {31'd0, flags[5]}, 32'd1);
        sw_clr_imask = 1'b1;
        settle();
        sw_set_imask = 1'b1;
        settle();
        check("R12", {25'd0, flags}, {25'd0, 7'b0100000});

        // R14: restore beats a same-cycle ALU update
        restore = 1'b1; restore_bus = 7'b0000100;
        op_valid = 1'b1; op_class = 4'd6; result = 8'h80;
        settle();
        check("R14", {25'd0, flags}, {25'd0, 7'b0000100});

        // R14: entry beats a same-cycle restore
        int_enter = 1'b1; restore = 1'b1; restore_bus = 7'b0011111;
        settle();
        check("R14", {25'd0, flags}, {25'd0, 7'b0100100});

        // R14, R1: reset beats everything
        rst = 1'b1; int_enter = 1'b1; restore = 1'b1; restore_bus = 7'b0011111;
        op_valid = 1'b1; op_class = 4'd1; result = 8'hFF; alu_carry = 1'b1;
        settle();
        check("R14", {25'd0, flags}, {25'd0, 7'b1100000});

        // R12: software command and ALU update land together
        sw_clr_imask = 1'b1; op_valid = 1'b1; op_class = 4'd4; result = 8'h00;
        alu_carry = 1'b1;
        settle();
        check("R12", {25'd0, flags}, {25'd0, 7'b1000101});

        // R2: an unused class code changes nothing
        op_valid = 1'b1; op_class = 4'd12; result = 8'h80; alu_carry = 1'b0;
        settle();
        check("R2", {25'd0, flags}, {25'd0, 7'b1000101});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule